// File: doc/BRIEF.md
# Sectored Direct-Mapped Data Cache

This block is a direct-mapped data cache of 8 KB built from 512 lines of four 32-bit words. Each line holds one tag entry. The entry carries a separate valid flag for every word, so a line may be only partly present. A load that misses fetches a run of words from a word-wide memory port. The length of that run is chosen by software: 1, 2, 4 or 8 words. Stores always go out to memory, and a store that hits also updates the cached word.

Software controls the cache with an enable input, a refill-length field and a two-bit mode field. In tag-test mode, loads and stores reach the tag entries directly. This path is also the way to set the per-line lock flag. A locked line keeps its contents when a miss arrives for a different address.

The CPU side uses a request/done handshake. The CPU holds `cpu_req` and its operands until `cpu_done` pulses for one cycle. The memory side holds `mem_req` and its operands until `mem_ack` pulses, and read data arrives together with the acknowledge.

Top module: `dcache_sectored`

## Requirements
- R1: A byte address splits into tag bits 31..13, line index bits 12..4 and word-in-line bits 3..2. A load hits only when the stored tag matches and the addressed word's valid flag is set. A hit returns the cached word with no memory access.
- R2: A tag entry holds the tag in bits 23..5, the lock flag in bit 4 and the word valid flags in bits 3..0, where bit 0 is the lowest word of the line. With mode 11, a load returns the entry at the address's line index, zero-extended. A store in that mode writes wdata bits 23..0 into that entry. Neither makes a memory access.
- R3: The refill field maps 00 to 1 word, 01 to 2 words, 10 to 4 words and 11 to 8 words. Fill reads begin at the address aligned to the refill length and step upward one word per acknowledge.
- R4: When the tag matches but the addressed word is invalid, only the words of the refill window that are not yet valid are read.
- R5: A refill into a line that holds a different tag first clears all four valid flags. It then sets the flags of the words it fetches.
- R6: An 8-word refill covers the aligned even/odd pair of lines and writes the tag and valid flags of both.
- R7: While the enable input is low, no load hits and no line is filled. Each load becomes a single uncached word read, and the tag entries stay unchanged.
- R8: A locked line is never replaced by a miss with a different tag. That load is served by a single uncached read, and the entry is left as it was.
- R9: Every store outside tag-test mode makes exactly one memory write carrying the CPU byte enables. A store miss allocates nothing.
- R10: A store hit writes only the enabled byte lanes of the cached word. Byte 3 is bits 31..24, down to byte 0 in bits 7..0. The word's valid flag is unchanged.
- R11: After reset every tag entry is zero, so no word is valid and no line is locked. `cpu_done` and `mem_req` are low.
- R12: Each request ends with one single-cycle `cpu_done` pulse. `mem_req` and `mem_addr` hold steady until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Cache enable |
| cfg_refill | input | 2 | Refill length code |
| cfg_mode | input | 2 | Mode; 11 selects tag test |
| cpu_req | input | 1 | Request, held until done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load result, valid with done |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request, held until ack |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with ack |
| mem_ack | input | 1 | Memory acknowledge |

## Verification
Loads are run with every refill length. The exact sequence of memory read addresses is compared in each case, which separates aligned window fetches, partial fetches that skip valid words, and paired-line fills. Loads are also issued against a line holding another tag, a locked line and a disabled cache. Only the read count and the tag entry read back through tag-test mode can distinguish a replacement from an uncached bypass. Byte-masked stores are followed by a load that must hit with no memory read. Only a correct lane merge then returns the value the memory model holds.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOOKUP,
      ST_FILL,
      ST_UNCACHED,
      ST_WRITE,
      ST_DONE
   } dc_state_e;

   localparam logic [1:0] MODE_TAG_TEST = 2'b11;
   localparam int unsigned LINE_WORDS   = 4;
   localparam int unsigned ENT_META_W   = 5;  // lock flag + four valid flags

endpackage

// File: rtl/dcache_tag_store.sv
module dcache_tag_store #(
   parameter int unsigned LINES = 512,
   parameter int unsigned IDX_W = 9,
   parameter int unsigned ENT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] ra_idx,
   output logic [ENT_W-1:0] ra_ent,
   input  logic [IDX_W-1:0] rb_idx,
   output logic [ENT_W-1:0] rb_ent,
   input  logic             w0_en,
   input  logic [IDX_W-1:0] w0_idx,
   input  logic [ENT_W-1:0] w0_ent,
   input  logic             w1_en,
   input  logic [IDX_W-1:0] w1_idx,
   input  logic [ENT_W-1:0] w1_ent
);

   logic [ENT_W-1:0] entries [LINES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(LINES); i++) entries[i] <= '0;
      end else begin
         if (w0_en) entries[w0_idx] <= w0_ent;
         if (w1_en) entries[w1_idx] <= w1_ent;
      end
   end

   assign ra_ent = entries[ra_idx];
   assign rb_ent = entries[rb_idx];

   // R6: the two ports only ever update distinct lines of a pair
   assert_pair_write_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (w0_en && w1_en) |-> (w0_idx != w1_idx));

endmodule

// File: rtl/dcache_data_store.sv
module dcache_data_store #(
   parameter int unsigned WORDS = 2048,
   parameter int unsigned AW    = 11
) (
   input  logic          clk,
   input  logic [AW-1:0] raddr,
   output logic [31:0]   rdata,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [3:0]    be,
   input  logic [31:0]   wdata
);

   logic [31:0] words [WORDS];
   logic [31:0] lane_mask;

   for (genvar g = 0; g < 4; g++) begin : g_lane
      assign lane_mask[8*g +: 8] = {8{be[g]}};
   end

   always_ff @(posedge clk) begin
      if (we) words[waddr] <= (words[waddr] & ~lane_mask) | (wdata & lane_mask);
   end

   assign rdata = words[raddr];

endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
   import dcache_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned IDX_W  = 9,
   parameter int unsigned TAG_W  = 19,
   parameter int unsigned ENT_W  = 24
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_enable,
   input  logic [1:0]         cfg_refill,
   input  logic [1:0]         cfg_mode,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [3:0]         cpu_be,
   input  logic [31:0]        cpu_wdata,
   output logic [31:0]        cpu_rdata,
   output logic               cpu_done,
   output logic               mem_req,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [3:0]         mem_be,
   output logic [31:0]        mem_wdata,
   input  logic [31:0]        mem_rdata,
   input  logic               mem_ack,
   output logic [IDX_W-1:0]   ra_idx,
   input  logic [ENT_W-1:0]   ra_ent,
   output logic [IDX_W-1:0]   rb_idx,
   input  logic [ENT_W-1:0]   rb_ent,
   output logic               tw0_en,
   output logic [IDX_W-1:0]   tw0_idx,
   output logic [ENT_W-1:0]   tw0_ent,
   output logic               tw1_en,
   output logic [IDX_W-1:0]   tw1_idx,
   output logic [ENT_W-1:0]   tw1_ent,
   output logic [IDX_W+1:0]   d_raddr,
   input  logic [31:0]        d_rdata,
   output logic               d_we,
   output logic [IDX_W+1:0]   d_waddr,
   output logic [3:0]         d_be,
   output logic [31:0]        d_wdata
);

   localparam int unsigned WA_W = ADDR_W - 2;

   dc_state_e         state;
   logic              r_we, r_en, r_tt;
   logic [1:0]        r_size;
   logic [ADDR_W-1:0] r_addr;
   logic [3:0]        r_be;
   logic [31:0]       r_wdata, rdata_q;
   logic [2:0]        fcnt;

   // request fields
   logic [IDX_W-1:0] r_idx;
   logic [1:0]       r_word;
   logic [TAG_W-1:0] r_tag;
   assign r_idx  = r_addr[IDX_W+3:4];
   assign r_word = r_addr[3:2];
   assign r_tag  = r_addr[ADDR_W-1:IDX_W+4];

   // refill window
   logic [3:0]       n_words;
   logic [2:0]       low_mask, last_cnt;
   logic [WA_W-1:0]  fbase, fw;
   logic [IDX_W-1:0] f_idx;
   logic [1:0]       f_word;
   logic [TAG_W-1:0] f_tag;
   assign n_words  = 4'd1 << r_size;
   assign low_mask = 3'(n_words - 4'd1);
   assign last_cnt = low_mask;
   assign fbase    = {r_addr[ADDR_W-1:5], r_addr[4:2] & ~low_mask};
   assign fw       = fbase + WA_W'(fcnt);
   assign f_idx    = fw[IDX_W+1:2];
   assign f_word   = fw[1:0];
   assign f_tag    = fw[WA_W-1:IDX_W+2];

   // lookup decisions
   logic a_match, a_lock, hit, b_match, b_lock, can_fill, pair, f_need;
   assign ra_idx   = r_idx;
   assign rb_idx   = (state == ST_FILL) ? f_idx : (r_idx ^ IDX_W'(1));
   assign a_match  = (ra_ent[ENT_W-1:ENT_META_W] == r_tag);
   assign a_lock   = ra_ent[4];
   assign hit      = r_en && a_match && ra_ent[r_word];
   assign b_match  = (rb_ent[ENT_W-1:ENT_META_W] == r_tag);
   assign b_lock   = rb_ent[4];
   assign can_fill = r_en && (a_match || !a_lock);
   assign pair     = (r_size == 2'b11);
   assign f_need   = (rb_ent[ENT_W-1:ENT_META_W] == f_tag) && !rb_ent[f_word];

   assign d_raddr  = {r_idx, r_word};

   always_comb begin
      tw0_en = 1'b0; tw0_idx = r_idx; tw0_ent = '0;
      tw1_en = 1'b0; tw1_idx = r_idx ^ IDX_W'(1); tw1_ent = '0;
      d_we = 1'b0; d_waddr = {r_idx, r_word}; d_be = r_be; d_wdata = r_wdata;
      case (state)
         ST_LOOKUP: begin
            if (r_tt) begin
               if (r_we) begin
                  tw0_en  = 1'b1;
                  tw0_ent = r_wdata[ENT_W-1:0];
               end
            end else if (r_we) begin
               d_we = hit;
            end else if (!hit && can_fill) begin
               if (!a_match) begin
                  tw0_en  = 1'b1;
                  tw0_ent = {r_tag, 1'b0, 4'b0000};
               end
               if (pair && !b_match && !b_lock) begin
                  tw1_en  = 1'b1;
                  tw1_ent = {r_tag, 1'b0, 4'b0000};
               end
            end
         end
         ST_FILL: begin
            if (f_need && mem_ack) begin
               tw0_en  = 1'b1;
               tw0_idx = f_idx;
               tw0_ent = rb_ent | (ENT_W'(1) << f_word);
               d_we    = 1'b1;
               d_waddr = {f_idx, f_word};
               d_be    = 4'hF;
               d_wdata = mem_rdata;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         r_we    <= 1'b0;
         r_en    <= 1'b0;
         r_tt    <= 1'b0;
         r_size  <= 2'b00;
         r_addr  <= '0;
         r_be    <= '0;
         r_wdata <= '0;
         rdata_q <= '0;
         fcnt    <= '0;
      end else begin
         case (state)
            ST_IDLE: if (cpu_req) begin
               r_we    <= cpu_we;
               r_addr  <= cpu_addr;
               r_be    <= cpu_be;
               r_wdata <= cpu_wdata;
               r_en    <= cfg_enable;
               r_tt    <= (cfg_mode == MODE_TAG_TEST);
               r_size  <= cfg_refill;
               state   <= ST_LOOKUP;
            end
            ST_LOOKUP: begin
               if (r_tt) begin
                  rdata_q <= r_we ? 32'd0 : 32'(ra_ent);
                  state   <= ST_DONE;
               end else if (r_we) begin
                  state <= ST_WRITE;
               end else if (hit) begin
                  rdata_q <= d_rdata;
                  state   <= ST_DONE;
               end else if (can_fill) begin
                  fcnt  <= '0;
                  state <= ST_FILL;
               end else begin
                  state <= ST_UNCACHED;
               end
            end
            ST_FILL: if (!f_need || mem_ack) begin
               if (fcnt == last_cnt) state <= ST_LOOKUP;
               else fcnt <= fcnt + 3'd1;
            end
            ST_UNCACHED: if (mem_ack) begin
               rdata_q <= mem_rdata;
               state   <= ST_DONE;
            end
            ST_WRITE: if (mem_ack) state <= ST_DONE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign mem_req   = ((state == ST_FILL) && f_need) || (state == ST_UNCACHED) || (state == ST_WRITE);
   assign mem_we    = (state == ST_WRITE);
   assign mem_addr  = (state == ST_FILL) ? {fw, 2'b00} : (r_addr & ~ADDR_W'(3));
   assign mem_be    = (state == ST_WRITE) ? r_be : 4'hF;
   assign mem_wdata = r_wdata;
   assign cpu_done  = (state == ST_DONE);
   assign cpu_rdata = rdata_q;

   assert_mem_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

   assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   assert_store_no_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOOKUP && r_we) |=> (state != ST_FILL));

   assert_disabled_no_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_FILL) |-> r_en);

   assert_lock_keeps_tag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tw0_en && state == ST_LOOKUP && !r_tt && a_lock)
         |-> (tw0_ent[ENT_W-1:ENT_META_W] == ra_ent[ENT_W-1:ENT_META_W]));

   assert_tag_test_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_LOOKUP && r_tt) |=> (state == ST_DONE && !mem_req));

endmodule

// File: rtl/dcache_sectored.sv
module dcache_sectored #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned LINE_COUNT = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_enable,
   input  logic [1:0]        cfg_refill,
   input  logic [1:0]        cfg_mode,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [3:0]        cpu_be,
   input  logic [31:0]       cpu_wdata,
   output logic [31:0]       cpu_rdata,
   output logic              cpu_done,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack
);

   localparam int unsigned IDX_W = $clog2(LINE_COUNT);
   localparam int unsigned TAG_W = ADDR_W - IDX_W - 4;
   localparam int unsigned ENT_W = TAG_W + dcache_pkg::ENT_META_W;
   localparam int unsigned WORDS = LINE_COUNT * dcache_pkg::LINE_WORDS;

   if ((1 << IDX_W) != LINE_COUNT || LINE_COUNT < 2) begin : g_bad_lines
      $error("LINE_COUNT must be a power of two of at least 2");
   end
   if (ENT_W > 32 || TAG_W < 1) begin : g_bad_entry
      $error("tag entry must fit the 32-bit data bus");
   end

   logic [IDX_W-1:0] ra_idx, rb_idx, tw0_idx, tw1_idx;
   logic [ENT_W-1:0] ra_ent, rb_ent, tw0_ent, tw1_ent;
   logic             tw0_en, tw1_en, d_we;
   logic [IDX_W+1:0] d_raddr, d_waddr;
   logic [31:0]      d_rdata, d_wdata;
   logic [3:0]       d_be;

   dcache_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .ENT_W(ENT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_enable(cfg_enable), .cfg_refill(cfg_refill), .cfg_mode(cfg_mode),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_be(cpu_be),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
      .ra_idx(ra_idx), .ra_ent(ra_ent), .rb_idx(rb_idx), .rb_ent(rb_ent),
      .tw0_en(tw0_en), .tw0_idx(tw0_idx), .tw0_ent(tw0_ent),
      .tw1_en(tw1_en), .tw1_idx(tw1_idx), .tw1_ent(tw1_ent),
      .d_raddr(d_raddr), .d_rdata(d_rdata), .d_we(d_we), .d_waddr(d_waddr),
      .d_be(d_be), .d_wdata(d_wdata)
   );

   dcache_tag_store #(.LINES(LINE_COUNT), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_tags (
      .clk(clk), .rst_n(rst_n),
      .ra_idx(ra_idx), .ra_ent(ra_ent), .rb_idx(rb_idx), .rb_ent(rb_ent),
      .w0_en(tw0_en), .w0_idx(tw0_idx), .w0_ent(tw0_ent),
      .w1_en(tw1_en), .w1_idx(tw1_idx), .w1_ent(tw1_ent)
   );

   dcache_data_store #(.WORDS(WORDS), .AW(IDX_W + 2)) u_data (
      .clk(clk), .raddr(d_raddr), .rdata(d_rdata), .we(d_we), .waddr(d_waddr),
      .be(d_be), .wdata(d_wdata)
   );

endmodule

// File: tb/test_dcache_sectored.sv
module test_dcache_sectored;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_enable = 1'b1;
   logic [1:0]  cfg_refill = 2'b00;
   logic [1:0]  cfg_mode = 2'b00;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [3:0]  cpu_be = 4'hF;
   logic [31:0] cpu_rdata, mem_addr, mem_wdata;
   logic        cpu_done, mem_req, mem_we;
   logic [3:0]  mem_be;
   logic [31:0] mem_rdata = '0;
   logic        mem_ack = 1'b0;

   int tests = 0, failed = 0;
   int rd_total = 0, wr_total = 0;
   logic [31:0] model [4096];
   logic [31:0] rd_log [32];
   int rd0, wr0;

   always #5 clk = ~clk;

   dcache_sectored i_dcache_sectored (
      .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_refill(cfg_refill),
      .cfg_mode(cfg_mode), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
      .cpu_be(cpu_be), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // memory model: one acknowledge per request, read data returned with it
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_ack <= 1'b0;
      end else if (mem_req && !mem_ack) begin
         mem_ack <= 1'b1;
         if (mem_we) begin
            for (int b = 0; b < 4; b++)
               if (mem_be[b]) model[mem_addr[13:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            wr_total <= wr_total + 1;
         end else begin
            mem_rdata <= model[mem_addr[13:2]];
            rd_log[rd_total % 32] <= mem_addr;
            rd_total <= rd_total + 1;
         end
      end else begin
         mem_ack <= 1'b0;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic access(input logic we, input logic [31:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd);
      int guard;
      @(negedge clk);
      rd0 = rd_total; wr0 = wr_total;
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_be = be; cpu_wdata = wd;
      guard = 0;
      do begin
         @(negedge clk);
         guard++;
      end while (!cpu_done && guard < 200);
      rd = cpu_rdata;
      cpu_req = 1'b0;
      @(negedge clk);
      check("R12 done pulse", {31'd0, cpu_done}, 32'd0);
   endtask

   task automatic load(input logic [31:0] addr, output logic [31:0] rd);
      access(1'b0, addr, 4'hF, 32'd0, rd);
   endtask

   task automatic tag_read(input logic [31:0] addr, output logic [31:0] ent);
      cfg_mode = 2'b11;
      access(1'b0, addr, 4'hF, 32'd0, ent);
      cfg_mode = 2'b00;
   endtask

   task automatic tag_write(input logic [31:0] addr, input logic [31:0] ent);
      logic [31:0] dummy;
      cfg_mode = 2'b11;
      access(1'b1, addr, 4'hF, ent, dummy);
      cfg_mode = 2'b00;
   endtask

   task automatic t_reset;
      logic [31:0] e;
      check("R11 done low", {31'd0, cpu_done}, 32'd0);
      check("R11 mem_req low", {31'd0, mem_req}, 32'd0);
      tag_read(32'h0000_0050, e);
      check("R11 entry clear", e, 32'h0);
      check("R2 tag read no memory", rd_total - rd0 + wr_total - wr0, 0);
   endtask

   task automatic t_single_word;
      logic [31:0] d, e;
      cfg_refill = 2'b00;
      load(32'h0000_0100, d);
      check("R3 one-word miss reads", rd_total - rd0, 1);
      check("R3 read address", rd_log[rd0 % 32], 32'h0000_0100);
      check("R1 miss data", d, model[12'h040]);
      load(32'h0000_0100, d);
      check("R1 hit no memory", rd_total - rd0, 0);
      check("R1 hit data", d, model[12'h040]);
      tag_read(32'h0000_0100, e);
      check("R2 entry after fill", e, 32'h01);
   endtask

   task automatic t_four_word;
      logic [31:0] d, e;
      cfg_refill = 2'b10;
      load(32'h0000_0208, d);
      check("R3 four-word reads", rd_total - rd0, 4);
      for (int k = 0; k < 4; k++)
         check("R3 aligned ascending order", rd_log[(rd0 + k) % 32], 32'h200 + 32'(4*k));
      check("R1 four-word data", d, model[12'h082]);
      load(32'h0000_020C, d);
      check("R1 neighbour hit", rd_total - rd0, 0);
      tag_read(32'h0000_0200, e);
      check("R2 full line entry", e, 32'h0F);
   endtask

   task automatic t_partial;
      logic [31:0] d, e;
      cfg_refill = 2'b00;
      load(32'h0000_0314, d);
      cfg_refill = 2'b10;
      load(32'h0000_031C, d);
      check("R4 only missing words read", rd_total - rd0, 3);
      check("R4 first", rd_log[rd0 % 32], 32'h310);
      check("R4 second skips valid", rd_log[(rd0 + 1) % 32], 32'h318);
      check("R4 third", rd_log[(rd0 + 2) % 32], 32'h31C);
      check("R4 data", d, model[12'h0C7]);
      tag_read(32'h0000_0310, e);
      check("R4 entry", e, 32'h0F);
      cfg_refill = 2'b00;
   endtask

   task automatic t_replace;
      logic [31:0] d, e;
      cfg_refill = 2'b00;
      load(32'h0000_2104, d);
      check("R5 replace reads", rd_total - rd0, 1);
      check("R5 data", d, model[12'h841]);
      tag_read(32'h0000_0100, e);
      check("R5 old valid cleared", e, 32'h22);
      load(32'h0000_0100, d);
      check("R5 evicted word misses", rd_total - rd0, 1);
      tag_read(32'h0000_0100, e);
      check("R5 entry back", e, 32'h01);
   endtask

   task automatic t_pair;
      logic [31:0] d, e;
      cfg_refill = 2'b11;
      load(32'h0000_0414, d);
      check("R6 eight reads", rd_total - rd0, 8);
      for (int k = 0; k < 8; k++)
         check("R6 pair order", rd_log[(rd0 + k) % 32], 32'h400 + 32'(4*k));
      check("R6 data", d, model[12'h105]);
      tag_read(32'h0000_0400, e);
      check("R6 even line", e, 32'h0F);
      tag_read(32'h0000_0410, e);
      check("R6 odd line", e, 32'h0F);
      cfg_refill = 2'b00;
      load(32'h0000_0400, d);
      check("R6 pair hit", rd_total - rd0, 0);
   endtask

   task automatic t_disabled;
      logic [31:0] d, e;
      cfg_enable = 1'b0;
      cfg_refill = 2'b10;
      load(32'h0000_0400, d);
      check("R7 no hit when disabled", rd_total - rd0, 1);
      check("R7 data", d, model[12'h100]);
      load(32'h0000_0500, d);
      check("R7 single uncached read", rd_total - rd0, 1);
      tag_read(32'h0000_0500, e);
      check("R7 no fill", e, 32'h0);
      tag_read(32'h0000_0400, e);
      check("R7 entry kept", e, 32'h0F);
      cfg_enable = 1'b1;
      cfg_refill = 2'b00;
   endtask

   task automatic t_lock;
      logic [31:0] d, e;
      cfg_refill = 2'b00;
      tag_write(32'h0000_0600, 32'h10);
      load(32'h0000_2600, d);
      check("R8 uncached read", rd_total - rd0, 1);
      check("R8 data", d, model[12'h980]);
      tag_read(32'h0000_0600, e);
      check("R8 entry unchanged", e, 32'h10);
      load(32'h0000_2600, d);
      check("R8 still not cached", rd_total - rd0, 1);
      load(32'h0000_0600, d);
      check("R8 matching tag fills", rd_total - rd0, 1);
      tag_read(32'h0000_0600, e);
      check("R8 locked entry filled", e, 32'h11);
   endtask

   task automatic t_store_hit;
      logic [31:0] d, e;
      access(1'b1, 32'h0000_0204, 4'b0010, 32'hAABB_CCDD, d);
      check("R9 one write", wr_total - wr0, 1);
      check("R9 no read on store", rd_total - rd0, 0);
      load(32'h0000_0204, d);
      check("R10 hit after store", rd_total - rd0, 0);
      check("R10 byte1 merged", d, model[12'h081]);
      access(1'b1, 32'h0000_0204, 4'b1000, 32'h1122_3344, d);
      load(32'h0000_0204, d);
      check("R10 byte3 merged", d, model[12'h081]);
      check("R10 byte3 lane", {24'd0, d[31:24]}, 32'h11);
      tag_read(32'h0000_0200, e);
      check("R10 valid unchanged", e, 32'h0F);
   endtask

   task automatic t_store_miss;
      logic [31:0] d, e;
      access(1'b1, 32'h0000_0700, 4'hF, 32'h5A5A_0700, d);
      check("R9 miss writes", wr_total - wr0, 1);
      tag_read(32'h0000_0700, e);
      check("R9 no allocate", e, 32'h0);
      load(32'h0000_0700, d);
      check("R9 reload misses", rd_total - rd0, 1);
      check("R9 written data", d, 32'h5A5A_0700);
   endtask

   task automatic t_tag_test;
      logic [31:0] e;
      tag_write(32'h0000_0780, 32'hFFFF_FFFF);
      check("R2 store no memory", rd_total - rd0 + wr_total - wr0, 0);
      tag_read(32'h0000_0780, e);
      check("R2 entry width", e, 32'h00FF_FFFF);
   endtask

   initial begin
      #1_000_000;
      tests++; failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4096; i++) model[i] = 32'hD000_0000 ^ (32'(i) * 32'h0001_0101);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single_word();
      t_four_word();
      t_partial();
      t_replace();
      t_pair();
      t_disabled();
      t_lock();
      t_store_hit();
      t_store_miss();
      t_tag_test();
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

endmodule